// File: doc/BRIEF.md
# Routed Odd/Even Clock Post-Divider Bank

This block turns two oscillator clocks and one reference clock into five divided clock outputs. Each output channel has a fixed list of sources it may take. It divides the chosen source by a 5-bit ratio that may be odd or even. Three of the channels add a power-of-two stage (1, 2, 4 or 8) after that ratio. The duty cycle stays at half the output period. Even overall ratios use a single rising-edge counter. Odd overall ratios add half a source period, taken from a falling-edge copy of the counter waveform. A ratio field of 0 or 1 passes the source clock straight through.

One enable input starts and stops all channels. Each channel resynchronises it in its own source-clock domain with two rising-edge stages. While a channel is stopped, its counters are cleared and its output is held low. Every restart therefore opens with a full high phase. Ratio, post-divider and source fields may change only while the enable is low. Switching the source while a channel runs is not supported. There is no data stream, so all pins are plain control or clock pins with no valid/ready handshake.

Top module: `clk_route_div`

## Requirements
- R1: While `rst_n` is low, every bit of `clk_o` is low.
- R2: Channel k samples `en_i` on each rising edge of its source clock. The channel runs at source rising edge n exactly when `en_i` was sampled high at edge n-2. On its first running edge, a dividing channel drives its output high.
- R3: The overall ratio is R = max(P,1) × 2^S. P is `p_ratio_i[5k+4:5k]`. S is `post_sel_i[2k+1:2k]`, where the codes 0..3 select 1, 2, 4 and 8. S applies only to channels 1, 2 and 3. Channels 0 and 4 ignore their S field.
- R4: For even R, a running output is high for R/2 source periods and then low for R/2 source periods, starting high.
- R5: For odd R ≥ 3, a running output is high for R source half-periods and then low for R half-periods, starting high at a rising edge. The falling edge of the source sets the half-period step.
- R6: When R = 1 (P of 0 or 1 and no power-of-two stage), a running output follows its source clock level. A stopped output is low.
- R7: Routing uses select bit k, `src_sel_i[k]`. Channel 0 always takes vco2. Channel 1 takes vco1 when bit 1 is 0 and the reference when it is 1. Channel 2 always takes the reference. Channel 3 takes vco2 when bit 3 is 0 and the reference when it is 1. Channel 4 always takes the reference. Select bits 0, 2 and 4 have no effect.
- R8: At the first source rising edge at which a channel is no longer running, its output goes low and stays low. A later restart begins a fresh period in the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| vco1_clk | input | 1 | First oscillator clock |
| vco2_clk | input | 1 | Second oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable, resynchronised per channel |
| p_ratio_i | input | 25 | Five 5-bit main ratios, channel k at bits [5k+4:5k] |
| post_sel_i | input | 10 | Five 2-bit power-of-two codes, channel k at bits [2k+1:2k] |
| src_sel_i | input | 5 | Source select, bit k for channel k |
| clk_o | output | 5 | Divided clock outputs, bit k for channel k |

## Verification
The assertions assume that ratio, post-divider and source fields hold steady whenever the enable has been high for two consecutive reference samples. They also assume that the enable and the configuration change away from every clock edge. The stimulus honours both assumptions. It lowers the enable, waits several reference periods, changes the configuration, waits again and only then raises the enable. All input changes land on half-nanosecond offsets, and every clock edge falls on an even nanosecond.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int NUM_OUT = 5;
  localparam int PW      = 5;
  localparam int SW      = 2;
  localparam int RW      = PW + (1 << SW) - 1;

  typedef enum logic [1:0] {
    SRC_VCO1 = 2'd0,
    SRC_VCO2 = 2'd1,
    SRC_REF  = 2'd2
  } src_e;

  localparam logic [NUM_OUT-1:0] ALT_REF_MASK  = 5'b01010;
  localparam logic [NUM_OUT-1:0] HAS_POST_MASK = 5'b01110;

  function automatic src_e base_src(input int idx);
    case (idx)
      0:       return SRC_VCO2;
      1:       return SRC_VCO1;
      3:       return SRC_VCO2;
      default: return SRC_REF;
    endcase
  endfunction

endpackage

// File: rtl/ratio_calc.sv
module ratio_calc #(
  parameter int PW = 5,
  parameter int SW = 2,
  parameter int RW = 8
) (
  input  logic [PW-1:0] p_i,
  input  logic [SW-1:0] s_i,
  output logic [RW-1:0] ratio_o
);

  logic [PW-1:0] base;

  always_comb begin
    base    = (p_i < PW'(2)) ? PW'(1) : p_i;
    ratio_o = RW'(base) << s_i;
  end

endmodule

// File: rtl/en_sync.sv
module en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/core_div.sv
module core_div #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [RW-1:0] ratio_i,
  output logic          clk_o
);

  logic          run;
  logic [RW-1:0] cnt;
  logic          pos_q;
  logic          neg_q;
  logic          active_q;
  logic          gate_q;
  logic          bypass;
  logic          odd;
  logic [RW-1:0] half;

  en_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (en_i),
    .q_o   (run)
  );

  assign bypass = (ratio_i == RW'(1));
  assign odd    = ratio_i[0] & ~bypass;
  assign half   = ratio_i >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      pos_q    <= 1'b0;
      active_q <= 1'b0;
    end else if (!run) begin
      cnt      <= '0;
      pos_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      active_q <= 1'b1;
      pos_q    <= (cnt < half);
      cnt      <= (cnt == ratio_i - RW'(1)) ? '0 : cnt + RW'(1);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      neg_q  <= pos_q;
      gate_q <= run;
    end
  end

  always_comb begin
    if (bypass)   clk_o = clk & gate_q;
    else if (odd) clk_o = pos_q | (neg_q & active_q);
    else          clk_o = pos_q;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio_i); // R4

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt == ratio_i - RW'(1)) |=> (cnt == '0)); // R4

  AST_FIRST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active_q) && !bypass) |-> pos_q); // R2

  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !bypass) |-> !clk_o); // R8

  AST_ODD_TAIL: assert property (@(negedge clk) disable iff (!rst_n)
    (odd && active_q && $fell(pos_q)) |-> clk_o); // R5

endmodule

// File: rtl/clk_route_div.sv
module clk_route_div #(
  parameter int NUM_OUT = clkdiv_pkg::NUM_OUT,
  parameter int PW      = clkdiv_pkg::PW,
  parameter int SW      = clkdiv_pkg::SW,
  parameter int RW      = PW + (1 << SW) - 1
) (
  input  logic                  ref_clk,
  input  logic                  vco1_clk,
  input  logic                  vco2_clk,
  input  logic                  rst_n,
  input  logic                  en_i,
  input  logic [NUM_OUT*PW-1:0] p_ratio_i,
  input  logic [NUM_OUT*SW-1:0] post_sel_i,
  input  logic [NUM_OUT-1:0]    src_sel_i,
  output logic [NUM_OUT-1:0]    clk_o
);

  import clkdiv_pkg::*;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
    localparam src_e BASE = base_src(i);
    logic          prim_clk;
    logic          src_clk;
    logic [SW-1:0] s_eff;
    logic [RW-1:0] ratio;

    if (BASE == SRC_VCO1)      begin : g_v1 assign prim_clk = vco1_clk; end
    else if (BASE == SRC_VCO2) begin : g_v2 assign prim_clk = vco2_clk; end
    else                       begin : g_rf assign prim_clk = ref_clk;  end

    if (ALT_REF_MASK[i]) begin : g_alt
      assign src_clk = src_sel_i[i] ? ref_clk : prim_clk;
    end else begin : g_fix
      logic unused_sel;
      assign unused_sel = src_sel_i[i];
      assign src_clk    = prim_clk;
    end

    if (HAS_POST_MASK[i]) begin : g_post
      assign s_eff = post_sel_i[SW*i +: SW];
    end else begin : g_nopost
      logic [SW-1:0] unused_post;
      assign unused_post = post_sel_i[SW*i +: SW];
      assign s_eff       = '0;
    end

    ratio_calc #(.PW(PW), .SW(SW), .RW(RW)) u_ratio (
      .p_i     (p_ratio_i[PW*i +: PW]),
      .s_i     (s_eff),
      .ratio_o (ratio)
    );

    core_div #(.RW(RW)) u_div (
      .clk     (src_clk),
      .rst_n   (rst_n),
      .en_i    (en_i),
      .ratio_i (ratio),
      .clk_o   (clk_o[i])
    );
  end

  AST_CFG_HELD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (en_i && $past(en_i)) |->
      ($stable(p_ratio_i) && $stable(post_sel_i) && $stable(src_sel_i))); // R3

  AST_RESET_LOW: assert property (@(posedge ref_clk)
    !rst_n |-> (clk_o == '0)); // R1

endmodule

// File: tb/sim_clk_route_div.sv
`timescale 1ns/100ps
module sim_clk_route_div;

  logic        ref_clk = 1'b0;
  logic        vco1_clk = 1'b0;
  logic        vco2_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [24:0] p_ratio = '0;
  logic [9:0]  post_sel = '0;
  logic [4:0]  src_sel = '0;
  logic [4:0]  clk_o;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  always #10 ref_clk  = ~ref_clk;
  always #6  vco1_clk = ~vco1_clk;
  always #4  vco2_clk = ~vco2_clk;

  clk_route_div u0 (
    .ref_clk    (ref_clk),
    .vco1_clk   (vco1_clk),
    .vco2_clk   (vco2_clk),
    .rst_n      (rst_n),
    .en_i       (en),
    .p_ratio_i  (p_ratio),
    .post_sel_i (post_sel),
    .src_sel_i  (src_sel),
    .clk_o      (clk_o)
  );

  task automatic check_bit(input int g, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s out%0d t=%0t actual=%b expected=%b", cur_req, g, $time, act, exp);
    end
  endtask

  function automatic int ratio_of(input int g);
    int p;
    int s;
    p = int'(p_ratio[5*g +: 5]);
    s = (g >= 1 && g <= 3) ? int'(post_sel[2*g +: 2]) : 0;
    if (p < 2) p = 1;
    return p << s;
  endfunction

  // Behavioural reference: half-period phase counter per channel
  for (genvar g = 0; g < 5; g++) begin : mdl
    logic sclk;
    bit   ea, eb, run_now, prev;
    int   h, rr;

    if (g == 0)      begin : s0 assign sclk = vco2_clk; end
    else if (g == 1) begin : s1 assign sclk = src_sel[1] ? ref_clk : vco1_clk; end
    else if (g == 3) begin : s3 assign sclk = src_sel[3] ? ref_clk : vco2_clk; end
    else             begin : sr assign sclk = ref_clk; end

    always @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
        ea = 0; eb = 0; run_now = 0; h = 0;
      end else begin
        rr      = ratio_of(g);
        prev    = run_now;
        run_now = eb;
        eb      = ea;
        ea      = en;
        if (run_now) h = prev ? (h + 2) % (2 * rr) : 0;
        #1 check_bit(g, clk_o[g], run_now && (h < rr));
      end
    end

    always @(negedge sclk) begin
      if (rst_n) begin
        #1 check_bit(g, clk_o[g], run_now && (((h + 1) % (2 * rr)) < rr));
      end
    end
  end

  task automatic wait_ref(input int n);
    repeat (n) @(posedge ref_clk);
    #0.5;
  endtask

  task automatic run_case(input string tag, input logic [24:0] p, input logic [9:0] s,
                          input logic [4:0] sel, input int cycles);
    en = 1'b0;
    wait_ref(8);
    cur_req  = tag;
    p_ratio  = p;
    post_sel = s;
    src_sel  = sel;
    wait_ref(4);
    en = 1'b1;
    wait_ref(cycles);
    en = 1'b0;
    wait_ref(8);
  endtask

  initial begin
    #35.5;
    checks++;
    if (clk_o !== 5'b0) begin
      fails++;
      $display("FAIL R1 reset t=%0t actual=%b expected=%b", $time, clk_o, 5'b0);
    end
    rst_n = 1'b1;
    wait_ref(4);
    // R4: even ratios, no power-of-two stage
    run_case("R4", {5'd10, 5'd8, 5'd2, 5'd6, 5'd4}, 10'b0, 5'b0, 300);
    // R5: odd ratios including the maximum field value
    run_case("R5", {5'd31, 5'd9, 5'd7, 5'd5, 5'd3}, 10'b0, 5'b0, 300);
    // R3: power-of-two stage; channels 0 and 4 carry code 3 that must be ignored
    run_case("R3", {5'd3, 5'd3, 5'd3, 5'd3, 5'd3},
             {2'd3, 2'd3, 2'd2, 2'd1, 2'd3}, 5'b0, 300);
    // R6: ratio fields 0 and 1 pass the source through; channel 1 P=1,S=1 gives 2
    run_case("R6", {5'd0, 5'd1, 5'd0, 5'd1, 5'd0},
             {2'd0, 2'd0, 2'd0, 2'd1, 2'd0}, 5'b0, 200);
    // R7: alternate reference routing, select bits 0,2,4 set but ignored
    run_case("R7", {5'd6, 5'd5, 5'd4, 5'd3, 5'd2},
             {2'd0, 2'd2, 2'd0, 2'd1, 2'd0}, 5'b11111, 300);
    // R5: longest overall ratio 31x8 on the reference path
    run_case("R5", {5'd31, 5'd31, 5'd31, 5'd31, 5'd31},
             {2'd0, 2'd3, 2'd3, 2'd3, 2'd0}, 5'b01000, 600);
    // R8 and R2: short stop/start pulses restart with a fresh high phase
    cur_req = "R8";
    p_ratio  = {5'd7, 5'd4, 5'd5, 5'd3, 5'd1};
    post_sel = {2'd0, 2'd0, 2'd1, 2'd0, 2'd0};
    src_sel  = 5'b00010;
    wait_ref(4);
    for (int k = 0; k < 6; k++) begin
      en = 1'b1;
      wait_ref(3 + k);
      en = 1'b0;
      wait_ref(2 + (k % 3));
    end
    cur_req = "R2";
    en = 1'b1;
    wait_ref(50);
    en = 1'b0;
    wait_ref(10);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog t=%0t actual=running expected=finished", $time);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule